// File: doc/BRIEF.md
# Channel Hit Rate Monitor

This block watches one channel's digitized samples through a private threshold comparator. Over a window of programmable length it counts how many times the signal rises above the threshold, and how many clock cycles have passed. It delivers the two numbers as a result pair with a valid flag, and software divides one by the other to obtain a rate. The block has no connection to the trigger or readout logic. Its counters therefore keep running while the channel is dead for acquisition.

The controller has two states. In `IDLE` the counters are held at zero. The transition `IDLE -> RUN` is taken on `start` when `clear` is low. In `RUN` both counters advance. At the window's last cycle the transition `RUN -> IDLE` (window end, one-shot mode) is taken, or `RUN -> RUN` (window end, continuous mode, counters restart). From either state, `clear` forces the transition to `IDLE`.

Top module: `rate_mon`

## Requirements
- R1: After reset, `busy`, `res_valid`, `res_ovf`, `res_hits` and `res_time` are all zero.
- R2: A hit is a cycle in which `sample > threshold` (unsigned, strict) while the previous cycle's sample was not above it. A level held above threshold counts once, and a sample equal to the threshold is not above it.
- R3: `start` in `IDLE` (with `clear` low) clears `res_valid` and opens a window of `win_len` cycles, with 0 taken as 1, beginning with the next clock. `busy` is high for exactly those cycles. After the window's last clock edge, `res_valid` is 1, `res_time` equals the window length and `res_hits` equals the hits seen in the window.
- R4: The hit count saturates at 2^HIT_W-1. A hit arriving at that maximum sets `res_ovf` for that window's result.
- R5: With `cont_mode` low at the window end, the block returns to `IDLE` and `busy` falls.
- R6: `clear` has priority over `start`. It aborts a window, and one cycle later `busy` and `res_valid` are 0 and both counters are zero.
- R7: With `cont_mode` high at the window end, the next window starts on the following cycle with no lost cycle. The results are refreshed at every window end and `res_valid` stays 1.
- R8: `win_len` is sampled only at the accepted `start`. A change to `win_len`, or a further `start`, during a window has no effect on that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample | input | SAMPLE_W | Digitized channel sample |
| threshold | input | SAMPLE_W | Comparator level |
| win_len | input | TIME_W | Window length in cycles |
| cont_mode | input | 1 | 1 = restart after each window |
| start | input | 1 | Open a window (in IDLE) |
| clear | input | 1 | Abort and zero counters and valid |
| busy | output | 1 | Window in progress |
| res_valid | output | 1 | Result registers hold a finished window |
| res_hits | output | HIT_W | Hits in the last window |
| res_time | output | TIME_W | Cycles in the last window |
| res_ovf | output | 1 | Hit count saturated in the last window |

## Verification
The bench targets the edges of the hit definition. These are a sample exactly at threshold, which a `>=` comparator would count, and a level held across a whole window, which a level counter would count as many hits. It drives sixteen hits into a four-bit counter to catch a count that wraps to zero or a missing overflow flag, and fifteen hits to catch an overflow raised too early. A zero window length, a `win_len` change and a repeated `start` mid-window would show as a wrong `res_time`. A continuous run would expose a window that swallows or repeats its boundary hit. A clear followed by a fresh window would expose counters that were not zeroed.

// File: rtl/rate_mon_pkg.sv
package rate_mon_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mon_state_t;
endpackage

// File: rtl/rate_mon_disc.sv
module rate_mon_disc #(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] threshold,
    output logic                hit
);
    logic above_now;
    logic above_q;

    assign above_now = sample > threshold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) above_q <= 1'b0;
        else        above_q <= above_now;
    end

    assign hit = above_now && !above_q;

    // R2: a crossing cannot repeat on consecutive cycles
    p_level_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/rate_mon_satcnt.sv
module rate_mon_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         ovf,
    output logic [W-1:0] cnt_nxt,
    output logic         ovf_nxt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_comb begin
        cnt_nxt = cnt;
        ovf_nxt = ovf;
        if (inc) begin
            if (cnt == MAXV) ovf_nxt = 1'b1;
            else             cnt_nxt = cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            ovf <= ovf_nxt;
        end
    end

    // R4: a saturated count never wraps
    p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !clr) |=> (cnt == MAXV));
endmodule

// File: rtl/rate_mon.sv
module rate_mon
    import rate_mon_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int TIME_W   = 16,
    parameter int HIT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] threshold,
    input  logic [TIME_W-1:0]   win_len,
    input  logic                cont_mode,
    input  logic                start,
    input  logic                clear,
    output logic                busy,
    output logic                res_valid,
    output logic [HIT_W-1:0]    res_hits,
    output logic [TIME_W-1:0]   res_time,
    output logic                res_ovf
);
    localparam logic [HIT_W-1:0]  HIT_MAX = {HIT_W{1'b1}};
    localparam logic [TIME_W-1:0] ONE_T   = TIME_W'(1);

    mon_state_t         st, st_nxt;
    logic [TIME_W-1:0]  win_q;
    logic [TIME_W-1:0]  time_q;
    logic               win_end;
    logic               hit;
    logic               cnt_clr;
    logic [HIT_W-1:0]   hits_q, hits_nxt;
    logic               ovf_q, ovf_nxt;

    rate_mon_disc #(.SAMPLE_W(SAMPLE_W)) u_disc (
        .clk(clk), .rst_n(rst_n), .sample(sample),
        .threshold(threshold), .hit(hit)
    );

    assign win_end = (st == ST_RUN) && (time_q == win_q - ONE_T);
    assign cnt_clr = clear || (st == ST_IDLE) || win_end;

    rate_mon_satcnt #(.W(HIT_W)) u_hits (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
        .inc(hit && st == ST_RUN),
        .cnt(hits_q), .ovf(ovf_q), .cnt_nxt(hits_nxt), .ovf_nxt(ovf_nxt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (!clear && start) st_nxt = ST_RUN;
            ST_RUN: begin
                if (clear)                      st_nxt = ST_IDLE;
                else if (win_end && !cont_mode) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // counters and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q     <= ONE_T;
            time_q    <= '0;
            res_valid <= 1'b0;
            res_hits  <= '0;
            res_time  <= '0;
            res_ovf   <= 1'b0;
        end else if (clear) begin
            time_q    <= '0;
            res_valid <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    time_q <= '0;
                    if (start) begin
                        win_q     <= (win_len == '0) ? ONE_T : win_len;
                        res_valid <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (win_end) begin
                        time_q    <= '0;
                        res_hits  <= hits_nxt;
                        res_ovf   <= ovf_nxt;
                        res_time  <= time_q + ONE_T;
                        res_valid <= 1'b1;
                    end else begin
                        time_q <= time_q + ONE_T;
                    end
                end
                default: time_q <= '0;
            endcase
        end
    end

    assign busy = (st == ST_RUN);

    // R3: elapsed count stays inside the window
    p_time_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (time_q < win_q));
    // R3: a valid result covers at least one cycle
    p_valid_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_time != '0));
    // R4: overflow only with a saturated count
    p_ovf_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ovf) |-> (res_hits == HIT_MAX));
    // R5: a window ending without clear leaves a result
    p_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(clear)) |-> res_valid);
    // R6: clear drops busy and valid
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!res_valid && !busy));
    // R7: valid persists across continuous windows
    p_contvalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && res_valid && !clear) |=> res_valid);
endmodule

// File: tb/rate_mon_tb.sv
module rate_mon_tb;
    localparam int SW = 12;
    localparam int TW = 16;
    localparam int HW = 4;
    localparam int THR = 100;
    localparam int NV = 8;
    // fields: win[47:32] pulses[31:24] high_cycles[23:16] amplitude[15:0]
    localparam logic [47:0] VEC [NV] = '{
        {16'd8,  8'd2,  8'd1, 16'd200},
        {16'd10, 8'd3,  8'd2, 16'd101},
        {16'd12, 8'd3,  8'd2, 16'd100},
        {16'd5,  8'd5,  8'd3, 16'd4095},
        {16'd20, 8'd20, 8'd4, 16'd300},
        {16'd64, 8'd16, 8'd1, 16'd200},
        {16'd60, 8'd15, 8'd2, 16'd200},
        {16'd0,  8'd1,  8'd1, 16'd200}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [SW-1:0] sample = '0, threshold = SW'(THR);
    logic [TW-1:0] win_len = '0;
    logic cont_mode = 1'b0, start = 1'b0, clear = 1'b0;
    logic busy, res_valid, res_ovf;
    logic [HW-1:0] res_hits;
    logic [TW-1:0] res_time;
    int errs = 0, checks = 0;

    always #10 clk = ~clk;

    rate_mon #(.SAMPLE_W(SW), .TIME_W(TW), .HIT_W(HW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sample(sample), .threshold(threshold),
        .win_len(win_len), .cont_mode(cont_mode), .start(start), .clear(clear),
        .busy(busy), .res_valid(res_valid), .res_hits(res_hits),
        .res_time(res_time), .res_ovf(res_ovf)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lvl(int k, int np, int hi, int amp);
        if (k < 1) return 0;
        if ((k - 1) / 4 < np && (k - 1) % 4 < hi) return amp;
        return 0;
    endfunction

    task automatic open_win(input int w, input bit c);
        @(negedge clk);
        sample = '0; win_len = TW'(w); cont_mode = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #(20ns * 200000);
        errs++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 valid", int'(res_valid), 0);
        chk("R1 hits", int'(res_hits), 0);
        chk("R1 time", int'(res_time), 0);
        chk("R1 ovf", int'(res_ovf), 0);
        rst_n = 1'b1;

        // table of windows (R2 R3 R4 R5)
        for (int i = 0; i < NV; i++) begin
            int w, np, hi, amp, eff, cnt, exp_h, exp_o;
            bit prev, cur;
            w = int'(VEC[i][47:32]); np = int'(VEC[i][31:24]);
            hi = int'(VEC[i][23:16]); amp = int'(VEC[i][15:0]);
            eff = (w == 0) ? 1 : w;
            cnt = 0; prev = 1'b0;
            for (int k = 1; k <= eff; k++) begin
                cur = lvl(k, np, hi, amp) > THR;
                if (cur && !prev) cnt++;
                prev = cur;
            end
            exp_h = (cnt > 15) ? 15 : cnt;
            exp_o = (cnt > 15) ? 1 : 0;
            open_win(w, 1'b0);
            for (int k = 1; k <= eff; k++) begin
                sample = SW'(lvl(k, np, hi, amp));
                @(negedge clk);
            end
            sample = '0;
            chk("R3 valid", int'(res_valid), 1);
            chk("R2 hits", int'(res_hits), exp_h);
            chk("R3 time", int'(res_time), eff);
            chk("R4 ovf", int'(res_ovf), exp_o);
            chk("R5 idle", int'(busy), 0);
        end

        // R3: start clears the previous valid
        open_win(4, 1'b0);
        chk("R3 start clears valid", int'(res_valid), 0);
        chk("R3 busy", int'(busy), 1);
        repeat (4) @(negedge clk);

        // R8: win_len change and repeated start mid-window ignored
        open_win(6, 1'b0);
        win_len = TW'(50); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 window end", int'(busy), 0);
        chk("R8 time", int'(res_time), 6);

        // R6: clear mid-window, then a fresh window starts from zero
        open_win(20, 1'b0);
        sample = SW'(200);
        repeat (2) @(negedge clk);
        sample = '0;
        repeat (2) @(negedge clk);
        clear = 1'b1; start = 1'b1;
        @(negedge clk);
        clear = 1'b0; start = 1'b0;
        chk("R6 busy", int'(busy), 0);
        chk("R6 valid", int'(res_valid), 0);
        open_win(4, 1'b0);
        sample = SW'(200);
        @(negedge clk);
        sample = '0;
        repeat (3) @(negedge clk);
        chk("R6 fresh hits", int'(res_hits), 1);

        // R7: continuous windows, boundary hit lands in second window
        open_win(8, 1'b1);
        for (int k = 1; k <= 16; k++) begin
            sample = (k == 1 || k == 5 || k == 9) ? SW'(200) : '0;
            @(negedge clk);
            if (k == 8) begin
                chk("R7 first valid", int'(res_valid), 1);
                chk("R7 first hits", int'(res_hits), 2);
                chk("R7 still busy", int'(busy), 1);
            end
        end
        chk("R7 second hits", int'(res_hits), 1);
        chk("R7 second time", int'(res_time), 8);
        chk("R7 valid kept", int'(res_valid), 1);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        chk("R6 stop continuous", int'(busy), 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule